// File: doc/BRIEF.md
# Vector Floating-Point Classify Unit

This block classifies every element of one vector register operand as a floating-point value. It writes the result into a destination vector. The element format is chosen per operation: half (16-bit), single (32-bit) or double (64-bit) precision. Each element that is classified receives a 10-bit one-hot class code. The code is zero-extended to the element width, so the destination element is as wide as the source element.

An operation begins with a one-cycle `start` while the unit is idle. The unit captures the source vector, the old destination contents, the mask register, the mask enable, the vector length `vl` and the maximum vector length `vlmax`. It then walks the element indices one per clock, from 0 up to `vlmax-1`:

- An index below `vl` that is active is classified.
- An index below `vl` that is masked off keeps its old contents.
- An index from `vl` up to `vlmax-1` is cleared to zero.
- Elements at `vlmax` and above are never touched.

When the walk ends, the unit raises a one-cycle `done`. The finished vector stays on `result_vec` until the next accepted start. One classifier serves all three formats. It raises no exception flags of any kind, signalling NaNs included.

Top module: `vfc_classify_unit`

## Requirements
- R1: The class code is one-hot, with these bit meanings: bit 0 is -infinity, bit 1 is -normal, bit 2 is -subnormal, bit 3 is -zero, bit 4 is +zero, bit 5 is +subnormal, bit 6 is +normal, bit 7 is +infinity, bit 8 is signalling NaN and bit 9 is quiet NaN.
- R2: The `fmt` input selects the element width.
  - Code 0 is 16-bit (5 exponent bits, 10 fraction bits).
  - Code 1 is 32-bit (8 exponent bits, 23 fraction bits).
  - Code 2 is 64-bit (11 exponent bits, 52 fraction bits).
  - Code 3 behaves as code 2.
  - Element i occupies bits [i*W +: W] of the vector, where W is the element width.
  - The code is written into bits [9:0] of the destination element, and all higher bits are zero.
- R3: Cases are decided in a fixed priority order:
  1. infinity (exponent all ones, fraction zero);
  2. zero (exponent and fraction zero);
  3. subnormal (exponent zero, fraction nonzero);
  4. NaN (exponent all ones, fraction nonzero);
  5. normal, for everything else.

  For every case except NaN, the sign bit picks the negative or the positive code.
- R4: A NaN ignores its sign. It is quiet (bit 9) when the top fraction bit is 1, and signalling (bit 8) otherwise.
- R5: With `vm_en` low, an element i < vl whose `mask_bits[i]` is 0 keeps its old destination value.
- R6: With `vm_en` high, every element i < vl is classified, whatever `mask_bits` holds.
- R7: Elements with vl <= i < vlmax are written as zero. Elements with i >= vlmax keep their old value. The caller keeps vl <= vlmax <= VLEN_BITS/W.
- R8: After reset, `busy`, `done` and `result_vec` are zero. `done` is a single-cycle pulse seen max(vlmax,1) clock edges after the edge that accepts `start`. `result_vec` holds its value until the next accepted start.
- R9: A `start` that arrives while `busy` is high is ignored, along with the inputs that come with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| fmt | input | 2 | Element format code |
| vm_en | input | 1 | 1 = unmasked, 0 = honour `mask_bits` |
| vl | input | 4 | Number of body elements |
| vlmax | input | 4 | Body plus tail element count |
| mask_bits | input | 8 | Per-element enable, bit i for element i |
| src_vec | input | 128 | Source vector |
| old_vec | input | 128 | Previous destination contents |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result_vec | output | 128 | Destination vector |

## Verification
The bench drives inputs on the falling edge. It then counts falling edges after the accepting edge until `done` is seen, and requires the count to be exactly max(vlmax,1). The result vector is compared in that same sample. One cycle later the bench checks that `done` has dropped and that the result has not moved. For the ignored-start case, a second `start` with a different source and length is applied in the first busy cycle. The result is then still compared against the first operation's expectation, at the first operation's latency.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

    localparam int CLS_W    = 10;
    localparam int ELEM_MAX = 64;

    // class code bit positions
    localparam int CB_NEG_INF  = 0;
    localparam int CB_NEG_NORM = 1;
    localparam int CB_NEG_SUB  = 2;
    localparam int CB_NEG_ZERO = 3;
    localparam int CB_POS_ZERO = 4;
    localparam int CB_POS_SUB  = 5;
    localparam int CB_POS_NORM = 6;
    localparam int CB_POS_INF  = 7;
    localparam int CB_SNAN     = 8;
    localparam int CB_QNAN     = 9;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2,
        FMT_ALTDBL = 2'd3
    } fmt_e;

    // summary of one element's fields, independent of format
    typedef struct packed {
        logic sign;
        logic exp_ones;
        logic exp_zero;
        logic frac_zero;
        logic frac_top;
    } fp_fields_t;

    function automatic logic [CLS_W-1:0] cls_bit(input int pos);
        logic [CLS_W-1:0] v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/vfc_field_probe.sv
module vfc_field_probe
    import vfc_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] bits,
    output fp_fields_t            flds
);
    localparam int SIGN_POS = EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = bits[SIGN_POS-1 -: EXP_W];
    assign frac_f = bits[FRAC_W-1:0];

    always_comb begin
        flds.sign      = bits[SIGN_POS];
        flds.exp_ones  = &exp_f;
        flds.exp_zero  = ~|exp_f;
        flds.frac_zero = ~|frac_f;
        flds.frac_top  = frac_f[FRAC_W-1];
    end

endmodule

// File: rtl/vfc_classifier.sv
module vfc_classifier
    import vfc_pkg::*;
(
    input  logic [ELEM_MAX-1:0] elem,
    input  fmt_e                fmt,
    output fp_fields_t          flds,
    output logic [CLS_W-1:0]    cls
);
    fp_fields_t probe_f [3];

    // one field probe per format, all looking at the low bits of the element
    for (genvar g = 0; g < 3; g++) begin : g_fmt
        localparam int EW = (g == 0) ? 5  : ((g == 1) ? 8  : 11);
        localparam int FW = (g == 0) ? 10 : ((g == 1) ? 23 : 52);
        vfc_field_probe #(
            .EXP_W  (EW),
            .FRAC_W (FW)
        ) u_probe (
            .bits (elem[EW+FW:0]),
            .flds (probe_f[g])
        );
    end

    always_comb begin
        case (fmt)
            FMT_HALF:   flds = probe_f[0];
            FMT_SINGLE: flds = probe_f[1];
            default:    flds = probe_f[2];
        endcase
    end

    // priority: infinity, zero, subnormal, NaN, normal
    always_comb begin
        if (flds.exp_ones && flds.frac_zero) begin
            cls = flds.sign ? cls_bit(CB_NEG_INF) : cls_bit(CB_POS_INF);
        end else if (flds.exp_zero && flds.frac_zero) begin
            cls = flds.sign ? cls_bit(CB_NEG_ZERO) : cls_bit(CB_POS_ZERO);
        end else if (flds.exp_zero) begin
            cls = flds.sign ? cls_bit(CB_NEG_SUB) : cls_bit(CB_POS_SUB);
        end else if (flds.exp_ones) begin
            cls = flds.frac_top ? cls_bit(CB_QNAN) : cls_bit(CB_SNAN);
        end else begin
            cls = flds.sign ? cls_bit(CB_NEG_NORM) : cls_bit(CB_POS_NORM);
        end
    end

endmodule

// File: rtl/vfc_lane_read.sv
module vfc_lane_read
    import vfc_pkg::*;
#(
    parameter int VLEN_BITS = 128,
    parameter int IDXW      = 4
) (
    input  logic [VLEN_BITS-1:0] vec,
    input  logic [IDXW-1:0]      idx,
    input  fmt_e                 fmt,
    output logic [ELEM_MAX-1:0]  elem
);
    localparam int NE_H = VLEN_BITS / 16;
    localparam int NE_S = VLEN_BITS / 32;
    localparam int NE_D = VLEN_BITS / 64;

    always_comb begin
        elem = '0;
        case (fmt)
            FMT_HALF:
                if (int'(idx) < NE_H) elem[15:0] = vec[int'(idx)*16 +: 16];
            FMT_SINGLE:
                if (int'(idx) < NE_S) elem[31:0] = vec[int'(idx)*32 +: 32];
            default:
                if (int'(idx) < NE_D) elem = vec[int'(idx)*64 +: 64];
        endcase
    end

endmodule

// File: rtl/vfc_lane_write.sv
module vfc_lane_write
    import vfc_pkg::*;
#(
    parameter int VLEN_BITS = 128,
    parameter int IDXW      = 4
) (
    input  logic [VLEN_BITS-1:0] vec_in,
    input  logic [IDXW-1:0]      idx,
    input  fmt_e                 fmt,
    input  logic                 wr_en,
    input  logic [ELEM_MAX-1:0]  wdata,
    output logic [VLEN_BITS-1:0] vec_out
);
    localparam int NE_H = VLEN_BITS / 16;
    localparam int NE_S = VLEN_BITS / 32;
    localparam int NE_D = VLEN_BITS / 64;

    always_comb begin
        vec_out = vec_in;
        if (wr_en) begin
            case (fmt)
                FMT_HALF:
                    if (int'(idx) < NE_H) vec_out[int'(idx)*16 +: 16] = wdata[15:0];
                FMT_SINGLE:
                    if (int'(idx) < NE_S) vec_out[int'(idx)*32 +: 32] = wdata[31:0];
                default:
                    if (int'(idx) < NE_D) vec_out[int'(idx)*64 +: 64] = wdata;
            endcase
        end
    end

endmodule

// File: rtl/vfc_classify_unit.sv
module vfc_classify_unit
    import vfc_pkg::*;
#(
    parameter int VLEN_BITS = 128,
    localparam int MAX_EL   = VLEN_BITS / 16,
    localparam int IDXW     = $clog2(MAX_EL + 1),
    localparam int MW       = $clog2(MAX_EL)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [1:0]           fmt,
    input  logic                 vm_en,
    input  logic [IDXW-1:0]      vl,
    input  logic [IDXW-1:0]      vlmax,
    input  logic [MAX_EL-1:0]    mask_bits,
    input  logic [VLEN_BITS-1:0] src_vec,
    input  logic [VLEN_BITS-1:0] old_vec,
    output logic                 busy,
    output logic                 done,
    output logic [VLEN_BITS-1:0] result_vec
);
    localparam logic [IDXW-1:0] IDX_ONE = IDXW'(1);

    logic                 busy_q, done_q, vm_q;
    fmt_e                 fmt_q;
    logic [IDXW-1:0]      idx_q, vl_q, vlmax_q;
    logic [MAX_EL-1:0]    mask_q;
    logic [VLEN_BITS-1:0] src_q, dst_q, dst_next;

    logic [ELEM_MAX-1:0]  elem;
    fp_fields_t           flds;
    logic [CLS_W-1:0]     cls;
    logic                 in_body, in_tail, active, wr_en, last_step;
    logic [ELEM_MAX-1:0]  wdata;

    vfc_lane_read #(
        .VLEN_BITS (VLEN_BITS),
        .IDXW      (IDXW)
    ) u_rd (
        .vec  (src_q),
        .idx  (idx_q),
        .fmt  (fmt_q),
        .elem (elem)
    );

    vfc_classifier u_cls (
        .elem (elem),
        .fmt  (fmt_q),
        .flds (flds),
        .cls  (cls)
    );

    always_comb begin
        in_body   = idx_q < vl_q;
        in_tail   = !in_body && (idx_q < vlmax_q);
        active    = vm_q || mask_q[idx_q[MW-1:0]];
        wr_en     = (in_body && active) || in_tail;
        wdata     = in_body ? ELEM_MAX'(cls) : '0;
        last_step = (vlmax_q == '0) || (idx_q == vlmax_q - IDX_ONE);
    end

    vfc_lane_write #(
        .VLEN_BITS (VLEN_BITS),
        .IDXW      (IDXW)
    ) u_wr (
        .vec_in  (dst_q),
        .idx     (idx_q),
        .fmt     (fmt_q),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .vec_out (dst_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            vm_q    <= 1'b0;
            fmt_q   <= FMT_HALF;
            idx_q   <= '0;
            vl_q    <= '0;
            vlmax_q <= '0;
            mask_q  <= '0;
            src_q   <= '0;
            dst_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q  <= 1'b1;
                    fmt_q   <= fmt_e'(fmt);
                    vm_q    <= vm_en;
                    vl_q    <= vl;
                    vlmax_q <= vlmax;
                    mask_q  <= mask_bits;
                    src_q   <= src_vec;
                    dst_q   <= old_vec;
                    idx_q   <= '0;
                end
            end else begin
                dst_q <= dst_next;
                if (last_step) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + IDX_ONE;
                end
            end
        end
    end

    assign busy       = busy_q;
    assign done       = done_q;
    assign result_vec = dst_q;

    AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> ($countones(cls) == 1)); // R1
    AST_NAN_CLASS: assert property (@(posedge clk) disable iff (rst)
        (busy_q && flds.exp_ones && !flds.frac_zero) |-> (cls[CB_SNAN] || cls[CB_QNAN])); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !start) |=> $stable(result_vec)); // R8
    AST_VL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_q) |-> (vl <= vlmax)); // R7
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !last_step && start) |=> (busy_q && $stable(vl_q) && $stable(src_q))); // R9

endmodule

// File: tb/tb_vfc_classify_unit.sv
module tb_vfc_classify_unit;

    localparam int VB = 128;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   fmt = 2'd0;
    logic         vm_en = 1'b1;
    logic [3:0]   vl = '0;
    logic [3:0]   vlmax = '0;
    logic [7:0]   mask_bits = '0;
    logic [VB-1:0] src_vec = '0;
    logic [VB-1:0] old_vec = '0;
    logic         busy, done;
    logic [VB-1:0] result_vec;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    vfc_classify_unit #(.VLEN_BITS(VB)) dut (
        .clk(clk), .rst(rst), .start(start), .fmt(fmt), .vm_en(vm_en),
        .vl(vl), .vlmax(vlmax), .mask_bits(mask_bits), .src_vec(src_vec),
        .old_vec(old_vec), .busy(busy), .done(done), .result_vec(result_vec)
    );

    task automatic chk(input bit ok, input string req, input logic [VB-1:0] act,
                       input logic [VB-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] ref_class(input int f, input logic [63:0] x);
        int ew, fw;
        logic [63:0] fr, e, emax;
        logic s;
        ew = (f == 0) ? 5 : ((f == 1) ? 8 : 11);
        fw = (f == 0) ? 10 : ((f == 1) ? 23 : 52);
        fr = x & ((64'd1 << fw) - 64'd1);
        emax = (64'd1 << ew) - 64'd1;
        e = (x >> fw) & emax;
        s = x[ew+fw];
        if (e == emax && fr == 0) return s ? 10'h001 : 10'h080;
        if (e == 0 && fr == 0)    return s ? 10'h008 : 10'h010;
        if (e == 0)               return s ? 10'h004 : 10'h020;
        if (e == emax)            return fr[fw-1] ? 10'h200 : 10'h100;
        return s ? 10'h002 : 10'h040;
    endfunction

    function automatic logic [VB-1:0] ref_vec(input int f, input bit v, input int l,
            input int lm, input logic [7:0] m, input logic [VB-1:0] s,
            input logic [VB-1:0] o);
        int esz, ne;
        logic [VB-1:0] out, em, lane;
        esz = 16 << f;
        ne = VB / esz;
        out = o;
        for (int i = 0; i < ne; i++) begin
            em = ((VB'(1) << esz) - VB'(1)) << (i * esz);
            lane = (s & em) >> (i * esz);
            if (i < l) begin
                if (v || m[i])
                    out = (out & ~em) | (VB'(ref_class(f, lane[63:0])) << (i * esz));
            end else if (i < lm) begin
                out = out & ~em;
            end
        end
        return out;
    endfunction

    function automatic logic [63:0] gen_elem(input int f);
        int ew, fw;
        logic [63:0] e, fr, r;
        ew = (f == 0) ? 5 : ((f == 1) ? 8 : 11);
        fw = (f == 0) ? 10 : ((f == 1) ? 23 : 52);
        case ($urandom % 4)
            0: e = 0;
            1: e = (64'd1 << ew) - 64'd1;
            default: e = {$urandom, $urandom} & ((64'd1 << ew) - 64'd1);
        endcase
        case ($urandom % 3)
            0: fr = 0;
            1: fr = 64'd1 << (fw - 1);
            default: fr = {$urandom, $urandom} & ((64'd1 << fw) - 64'd1);
        endcase
        r = (64'($urandom % 2) << (ew + fw)) | (e << fw) | fr;
        return r;
    endfunction

    // one operation, sampled on falling edges
    task automatic run(input int f, input bit v, input int l, input int lm,
                       input logic [7:0] m, input logic [VB-1:0] s,
                       input logic [VB-1:0] o, input bit poke,
                       input logic [VB-1:0] exp, input string req);
        int n;
        logic [VB-1:0] held;
        @(negedge clk);
        fmt = 2'(f); vm_en = v; vl = 4'(l); vlmax = 4'(lm);
        mask_bits = m; src_vec = s; old_vec = o; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 100) begin
            if (poke && n == 0) begin
                start = 1'b1; src_vec = ~s; vl = 4'd0; vm_en = ~v;
            end
            @(negedge clk);
            start = 1'b0; src_vec = s; vl = 4'(l); vm_en = v;
            n++;
        end
        chk(n == ((lm == 0) ? 1 : lm), {req, " R8 latency"}, VB'(n), VB'((lm == 0) ? 1 : lm));
        chk(result_vec === exp, req, result_vec, exp);
        held = result_vec;
        @(negedge clk);
        chk(!done && !busy && result_vec === held, {req, " R8 pulse/hold"}, result_vec, held);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [VB-1:0] s, o;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && result_vec == '0, "R8 reset", result_vec, '0);

        // R1 R3: every non-NaN class in half format
        s = {16'h7C00, 16'h3C00, 16'h0001, 16'h0000, 16'h8000, 16'h8001, 16'hBC00, 16'hFC00};
        run(0, 1, 8, 8, 8'h00, s, '1, 0,
            {16'h0080, 16'h0040, 16'h0020, 16'h0010, 16'h0008, 16'h0004, 16'h0002, 16'h0001},
            "R1 R3 half classes");

        // R4: NaN handling and normal boundaries
        s = {16'h0400, 16'h7BFF, 16'hFD00, 16'h7FFF, 16'hFE00, 16'h7E00, 16'hFC01, 16'h7C01};
        run(0, 1, 8, 8, 8'h00, s, '0, 0,
            {16'h0040, 16'h0040, 16'h0100, 16'h0200, 16'h0200, 16'h0200, 16'h0100, 16'h0100},
            "R4 half NaN");

        // R2: single and double formats, zero-extended codes
        s = {32'h80000000, 32'h00000001, 32'h7FC00000, 32'hFF800000};
        run(1, 1, 4, 4, 8'h00, s, '1, 0,
            {32'h00000008, 32'h00000020, 32'h00000200, 32'h00000001}, "R2 single");
        s = {64'h8000000000000001, 64'hFFF0000000000001};
        run(2, 1, 2, 2, 8'h00, s, '1, 0, {64'h4, 64'h100}, "R2 double");
        run(3, 1, 2, 2, 8'h00, s, '0, 0, {64'h4, 64'h100}, "R2 code3");

        // R5: masking keeps old values
        s = {16'h7C00, 16'h3C00, 16'h0001, 16'h0000, 16'h8000, 16'h8001, 16'hBC00, 16'hFC00};
        o = {8{16'hAAAA}};
        run(0, 0, 8, 8, 8'hA5, s, o, 0,
            {16'h0080, 16'hAAAA, 16'h0020, 16'hAAAA, 16'hAAAA, 16'h0004, 16'hAAAA, 16'h0001},
            "R5 masked");

        // R6: mask ignored when vm_en high
        run(0, 1, 8, 8, 8'h00, s, o, 0,
            {16'h0080, 16'h0040, 16'h0020, 16'h0010, 16'h0008, 16'h0004, 16'h0002, 16'h0001},
            "R6 unmasked");

        // R7: tail zeroing and untouched region above vlmax
        s = {32'h1, 32'h1, 32'h1, 32'h3F800000};
        run(1, 1, 1, 3, 8'h00, s, '1, 0,
            {32'hFFFFFFFF, 32'h0, 32'h0, 32'h00000040}, "R7 tail");
        run(0, 1, 0, 0, 8'h00, s, o, 0, o, "R7 vlmax zero");

        // R9: start during busy is ignored
        s = {16'h7C00, 16'h3C00, 16'h0001, 16'h0000, 16'h8000, 16'h8001, 16'hBC00, 16'hFC00};
        run(0, 1, 5, 8, 8'h00, s, '1, 1,
            {16'h0000, 16'h0000, 16'h0000, 16'h0010, 16'h0008, 16'h0004, 16'h0002, 16'h0001},
            "R9 busy start");

        // random mix: R1 R2 R3 R4 R5 R6 R7
        for (int t = 0; t < 60; t++) begin
            int f, ne, lm, l, esz;
            bit v;
            logic [7:0] m;
            f = $urandom % 3;
            esz = 16 << f;
            ne = VB / esz;
            lm = $urandom % (ne + 1);
            l = (lm == 0) ? 0 : ($urandom % (lm + 1));
            v = $urandom % 2;
            m = 8'($urandom);
            s = '0;
            for (int i = 0; i < ne; i++)
                s = s | (VB'(gen_elem(f)) << (i * esz));
            o = {$urandom, $urandom, $urandom, $urandom};
            run(f, v, l, lm, m, s, o, (t % 7 == 3) && lm > 1,
                ref_vec(f, v, l, lm, m, s, o), "R1 R2 R3 R4 R5 R6 R7 random");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule